// File: doc/BRIEF.md
# Scan-Line Sprite Selector and Fetcher

This block runs once per scan line, ahead of the pixel stage. A one-cycle start pulse captures the target line number and two mode bits: sprite width (8 or 16 pixels) and vertical doubling. The block then walks a table of 32 sprite entries in ascending index order. Each entry is four bytes. It reads only the first byte of each entry, the vertical position, and tests whether the sprite covers the captured line. Matching sprites are kept in four ordered slots. Slot 0 receives the lowest-numbered match and is the frontmost.

After the scan, the block revisits each filled slot. It reads the four table bytes of that sprite (vertical position, horizontal position, pattern number, colour byte). It then reads one or two bitmap bytes for the row of the sprite that falls on the line. All reads go through a simple request port to a shared byte memory, and each read returns its data on the following cycle. The slots keep their contents until the next start, so the pixel stage can consume them during the line. Slots that were not filled are flagged invalid.

Top module: `spr_line_eval`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `fifth_hit` are 0 and `slot_valid` is all zeros.
- R2: A `start` pulse seen while idle captures `line_num`, `size16` and `mag` and begins a scan. Changes on those inputs, and further `start` pulses, have no effect until `done` has been given.
- R3: Sprite i covers the line when row = (line − Y − 1) mod 256 is below H. Y is the byte at ATTR_BASE + 4·i. H is 8 when `size16`=0 and 16 when `size16`=1, doubled when `mag`=1.
- R4: Covering sprites fill slots 0,1,2,3 in ascending index order. `slot_valid` is a thermometer code with bit k set exactly when slot k was filled. `slot_num` field k holds the sprite index in bits [5k+4:5k].
- R5: If a fifth covering sprite is met, it is not stored. `fifth_hit` goes to 1, `fifth_idx` takes its index, and the scan ends there.
- R6: A Y byte equal to 0xD0 ends the scan. That sprite and all higher-numbered sprites are not considered.
- R7: For each filled slot holding sprite n, `slot_y`, `slot_x`, `slot_pat` and `slot_color` (byte k in bits [8k+7:8k]) take the bytes at ATTR_BASE + 4n + 0, +1, +2 and +3.
- R8: With r = row (halved when `mag`=1) and P the pattern number:
  - when `size16`=0, `slot_row0` is the byte at PAT_BASE + 8·P + r and `slot_row1` is 0;
  - when `size16`=1, `slot_row0` is the byte at PAT_BASE + 32·(P div 4) + r and `slot_row1` is the byte at that address + 16.
- R9: `mem_req` is high for one cycle per read, and `mem_rdata` is taken on the cycle after the request. One evaluation issues one read per Y byte examined, plus 5 reads per filled slot when `size16`=0 or 6 when `size16`=1.
- R10: `done` is a single-cycle pulse, after which `busy` is 0. The slot outputs and `fifth_hit` then hold until the next accepted `start`, which clears them.
- R11: `mem_req` is raised only while `busy` is 1, and every requested address lies inside the sprite table or the 2 KiB pattern area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin evaluation for the presented line |
| line_num | input | 8 | Line to be evaluated |
| size16 | input | 1 | 1 = 16-pixel sprites, 0 = 8-pixel |
| mag | input | 1 | 1 = sprites doubled vertically |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| slot_valid | output | NSLOT | Filled-slot flags |
| slot_num | output | NSLOT*IDX_W | Sprite index per slot |
| slot_y | output | NSLOT*8 | Vertical position byte per slot |
| slot_x | output | NSLOT*8 | Horizontal position byte per slot |
| slot_pat | output | NSLOT*8 | Pattern number per slot |
| slot_color | output | NSLOT*8 | Colour byte per slot |
| slot_row0 | output | NSLOT*8 | First bitmap byte of the covered row |
| slot_row1 | output | NSLOT*8 | Second bitmap byte (16-pixel mode) |
| fifth_hit | output | 1 | A fifth covering sprite was met |
| fifth_idx | output | IDX_W | Index of that sprite |

## Verification
Hand-built tables test specific cases:
- a terminator in entry 0, separating an empty result from a short scan;
- a terminator in the middle, showing that a covering sprite behind it is never picked;
- six sprites on one line, showing that four slots are filled and that the fifth index is latched;
- a position near 255 with a low line number, exercising the modulo-256 row under each size and doubling mode.

A swept line number over a pseudo-random table, in all four mode combinations, compares every slot byte and the read count against arithmetic in the bench. This separates errors in the height test, in the row halving and in the two pattern-address layouts.

A second start pulse with altered inputs in the middle of a run shows that the captured values govern the result.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SCAN,
      ST_FETCH,
      ST_DONE
   } spr_state_t;

   // bitmap row index width: covers 16 rows after halving
   localparam int SPR_ROW_W = 4;
   // bytes per sprite table entry
   localparam int SPR_ENTRY_BYTES = 4;
   // byte selectors used while fetching a slot
   localparam logic [2:0] SEL_Y    = 3'd0;
   localparam logic [2:0] SEL_X    = 3'd1;
   localparam logic [2:0] SEL_PAT  = 3'd2;
   localparam logic [2:0] SEL_COL  = 3'd3;
   localparam logic [2:0] SEL_ROW0 = 3'd4;
   localparam logic [2:0] SEL_ROW1 = 3'd5;
endpackage

// File: rtl/spr_hit_cmp.sv
module spr_hit_cmp
   import spr_eval_pkg::*;
#(
   parameter logic [7:0] TERM_Y = 8'hD0
) (
   input  logic [7:0]           y_pos,
   input  logic [7:0]           line,
   input  logic                 size16,
   input  logic                 mag,
   output logic                 term,
   output logic                 hit,
   output logic [SPR_ROW_W-1:0] row
);
   logic [7:0] diff;
   logic [7:0] height;

   always_comb begin
      diff   = line - y_pos - 8'd1;
      height = size16 ? 8'd16 : 8'd8;
      if (mag) height = height << 1;
      term = (y_pos == TERM_Y);
      hit  = !term && (diff < height);
      row  = mag ? diff[SPR_ROW_W:1] : diff[SPR_ROW_W-1:0];
   end
endmodule

// File: rtl/spr_slot_bank.sv
module spr_slot_bank
   import spr_eval_pkg::*;
#(
   parameter int NSLOT  = 4,
   parameter int IDX_W  = 5,
   parameter int SLOT_W = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       ld_en,
   input  logic [SLOT_W-1:0]          ld_slot,
   input  logic [IDX_W-1:0]           ld_num,
   input  logic [SPR_ROW_W-1:0]       ld_row,
   input  logic                       by_en,
   input  logic [SLOT_W-1:0]          by_slot,
   input  logic [2:0]                 by_sel,
   input  logic [7:0]                 by_data,
   output logic [NSLOT-1:0]           valid,
   output logic [NSLOT*IDX_W-1:0]     num,
   output logic [NSLOT*SPR_ROW_W-1:0] row,
   output logic [NSLOT*8-1:0]         ypos,
   output logic [NSLOT*8-1:0]         xpos,
   output logic [NSLOT*8-1:0]         pat,
   output logic [NSLOT*8-1:0]         color,
   output logic [NSLOT*8-1:0]         row0,
   output logic [NSLOT*8-1:0]         row1
);
   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      localparam logic [SLOT_W-1:0] ME = SLOT_W'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid[g]                       <= 1'b0;
            num[g*IDX_W +: IDX_W]          <= '0;
            row[g*SPR_ROW_W +: SPR_ROW_W]  <= '0;
            ypos[g*8 +: 8]                 <= '0;
            xpos[g*8 +: 8]                 <= '0;
            pat[g*8 +: 8]                  <= '0;
            color[g*8 +: 8]                <= '0;
            row0[g*8 +: 8]                 <= '0;
            row1[g*8 +: 8]                 <= '0;
         end else if (clear) begin
            valid[g]                       <= 1'b0;
            num[g*IDX_W +: IDX_W]          <= '0;
            row[g*SPR_ROW_W +: SPR_ROW_W]  <= '0;
            ypos[g*8 +: 8]                 <= '0;
            xpos[g*8 +: 8]                 <= '0;
            pat[g*8 +: 8]                  <= '0;
            color[g*8 +: 8]                <= '0;
            row0[g*8 +: 8]                 <= '0;
            row1[g*8 +: 8]                 <= '0;
         end else begin
            if (ld_en && ld_slot == ME) begin
               valid[g]                      <= 1'b1;
               num[g*IDX_W +: IDX_W]         <= ld_num;
               row[g*SPR_ROW_W +: SPR_ROW_W] <= ld_row;
            end
            if (by_en && by_slot == ME) begin
               case (by_sel)
                  SEL_Y:    ypos[g*8 +: 8]  <= by_data;
                  SEL_X:    xpos[g*8 +: 8]  <= by_data;
                  SEL_PAT:  pat[g*8 +: 8]   <= by_data;
                  SEL_COL:  color[g*8 +: 8] <= by_data;
                  SEL_ROW0: row0[g*8 +: 8]  <= by_data;
                  SEL_ROW1: row1[g*8 +: 8]  <= by_data;
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/spr_line_eval.sv
module spr_line_eval
   import spr_eval_pkg::*;
#(
   parameter int          NSPR      = 32,
   parameter int          NSLOT     = 4,
   parameter int          ADDR_W    = 14,
   parameter int unsigned ATTR_BASE = 32'h1B00,
   parameter int unsigned PAT_BASE  = 32'h3800,
   parameter logic [7:0]  TERM_Y    = 8'hD0,
   localparam int         IDX_W     = $clog2(NSPR),
   localparam int         SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   localparam int         CNT_W     = $clog2(NSLOT + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [7:0]             line_num,
   input  logic                   size16,
   input  logic                   mag,
   output logic                   mem_req,
   output logic [ADDR_W-1:0]      mem_addr,
   input  logic [7:0]             mem_rdata,
   output logic                   busy,
   output logic                   done,
   output logic [NSLOT-1:0]       slot_valid,
   output logic [NSLOT*IDX_W-1:0] slot_num,
   output logic [NSLOT*8-1:0]     slot_y,
   output logic [NSLOT*8-1:0]     slot_x,
   output logic [NSLOT*8-1:0]     slot_pat,
   output logic [NSLOT*8-1:0]     slot_color,
   output logic [NSLOT*8-1:0]     slot_row0,
   output logic [NSLOT*8-1:0]     slot_row1,
   output logic                   fifth_hit,
   output logic [IDX_W-1:0]       fifth_idx
);
   localparam logic [ADDR_W-1:0] ATTR_A = ATTR_BASE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] PAT_A  = PAT_BASE[ADDR_W-1:0];
   localparam logic [CNT_W-1:0]  FULL   = CNT_W'(NSLOT);

   // elaboration checks on the configuration
   if (NSPR < 2 || (1 << IDX_W) != NSPR) begin : g_bad_nspr
      $error("NSPR must be a power of two of at least 2");
   end
   if (NSLOT < 1 || NSLOT > NSPR) begin : g_bad_nslot
      $error("NSLOT must lie in 1..NSPR");
   end
   if (ATTR_BASE + SPR_ENTRY_BYTES * NSPR > (1 << ADDR_W)) begin : g_bad_attr
      $error("sprite table does not fit the address space");
   end
   if (PAT_BASE + 2048 > (1 << ADDR_W)) begin : g_bad_pat
      $error("pattern area does not fit the address space");
   end

   spr_state_t          state;
   logic                pend;
   logic [IDX_W-1:0]    idx;
   logic [CNT_W-1:0]    cnt;
   logic [SLOT_W-1:0]   fk;
   logic [2:0]          fb;
   logic [7:0]          line_q;
   logic                size_q;
   logic                mag_q;

   logic                       c_term, c_hit;
   logic [SPR_ROW_W-1:0]       c_row;
   logic [NSLOT*SPR_ROW_W-1:0] s_row;

   logic                 accept, ld_en, by_en, store, last_b;
   logic [IDX_W-1:0]     cur_num;
   logic [SPR_ROW_W-1:0] cur_row;
   logic [7:0]           cur_pat;
   logic [ADDR_W-1:0]    scan_a, attr_a, pat_a;

   spr_hit_cmp #(.TERM_Y(TERM_Y)) u_cmp (
      .y_pos  (mem_rdata),
      .line   (line_q),
      .size16 (size_q),
      .mag    (mag_q),
      .term   (c_term),
      .hit    (c_hit),
      .row    (c_row)
   );

   always_comb begin
      accept  = start && (state == ST_IDLE);
      store   = c_hit && (cnt != FULL);
      ld_en   = (state == ST_SCAN) && pend && !c_term && store;
      by_en   = (state == ST_FETCH) && pend;
      last_b  = size_q ? (fb == SEL_ROW1) : (fb == SEL_ROW0);
      cur_num = slot_num[fk*IDX_W +: IDX_W];
      cur_row = s_row[fk*SPR_ROW_W +: SPR_ROW_W];
      cur_pat = slot_pat[fk*8 +: 8];
   end

   spr_slot_bank #(.NSLOT(NSLOT), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .ld_en   (ld_en),
      .ld_slot (cnt[SLOT_W-1:0]),
      .ld_num  (idx),
      .ld_row  (c_row),
      .by_en   (by_en),
      .by_slot (fk),
      .by_sel  (fb),
      .by_data (mem_rdata),
      .valid   (slot_valid),
      .num     (slot_num),
      .row     (s_row),
      .ypos    (slot_y),
      .xpos    (slot_x),
      .pat     (slot_pat),
      .color   (slot_color),
      .row0    (slot_row0),
      .row1    (slot_row1)
   );

   // address generation
   always_comb begin
      scan_a = ATTR_A + ADDR_W'({idx, 2'b00});
      attr_a = ATTR_A + ADDR_W'({cur_num, 2'b00}) + ADDR_W'(fb);
      if (size_q)
         pat_a = PAT_A + ADDR_W'({cur_pat[7:2], 5'b0}) + ADDR_W'(cur_row)
               + ((fb == SEL_ROW1) ? ADDR_W'(16) : '0);
      else
         pat_a = PAT_A + ADDR_W'({cur_pat, 3'b0}) + ADDR_W'(cur_row);
      if (state == ST_SCAN)
         mem_addr = scan_a;
      else
         mem_addr = (fb < SEL_ROW0) ? attr_a : pat_a;
      mem_req = ((state == ST_SCAN) || (state == ST_FETCH)) && !pend;
      busy    = (state != ST_IDLE);
      done    = (state == ST_DONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pend      <= 1'b0;
         idx       <= '0;
         cnt       <= '0;
         fk        <= '0;
         fb        <= '0;
         line_q    <= '0;
         size_q    <= 1'b0;
         mag_q     <= 1'b0;
         fifth_hit <= 1'b0;
         fifth_idx <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state     <= ST_SCAN;
                  pend      <= 1'b0;
                  idx       <= '0;
                  cnt       <= '0;
                  fk        <= '0;
                  fb        <= '0;
                  line_q    <= line_num;
                  size_q    <= size16;
                  mag_q     <= mag;
                  fifth_hit <= 1'b0;
                  fifth_idx <= '0;
               end
            end
            ST_SCAN: begin
               if (!pend) begin
                  pend <= 1'b1;
               end else begin
                  pend <= 1'b0;
                  if (c_term) begin
                     state <= (cnt == '0) ? ST_DONE : ST_FETCH;
                  end else if (c_hit && !store) begin
                     fifth_hit <= 1'b1;
                     fifth_idx <= idx;
                     state     <= ST_FETCH;
                  end else begin
                     if (store) cnt <= cnt + 1'b1;
                     if (idx == IDX_W'(NSPR - 1))
                        state <= (cnt == '0 && !store) ? ST_DONE : ST_FETCH;
                     else
                        idx <= idx + 1'b1;
                  end
               end
            end
            ST_FETCH: begin
               if (!pend) begin
                  pend <= 1'b1;
               end else begin
                  pend <= 1'b0;
                  if (last_b) begin
                     fb <= '0;
                     if (CNT_W'(fk) + 1'b1 == cnt)
                        state <= ST_DONE;
                     else
                        fk <= fk + 1'b1;
                  end else begin
                     fb <= fb + 1'b1;
                  end
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spr_line_eval_chk.sv
module spr_line_eval_chk #(
   parameter int          NSPR      = 32,
   parameter int          NSLOT     = 4,
   parameter int          ADDR_W    = 14,
   parameter int unsigned ATTR_BASE = 32'h1B00,
   parameter int unsigned PAT_BASE  = 32'h3800
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [NSLOT-1:0]  slot_valid,
   input logic              fifth_hit
);
   localparam int unsigned ATTR_END = ATTR_BASE + 4 * NSPR;
   localparam int unsigned PAT_END  = PAT_BASE + 2048;

   logic in_range;
   assign in_range = (32'(mem_addr) >= ATTR_BASE && 32'(mem_addr) < ATTR_END) ||
                     (32'(mem_addr) >= PAT_BASE  && 32'(mem_addr) < PAT_END);

   // R11
   req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R11
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> in_range);

   // R9
   req_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && slot_valid == '0 && !fifth_hit));

   // R4
   valid_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid & (slot_valid + NSLOT'(1))) == '0);

   // R5
   fifth_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifth_hit |-> (&slot_valid));

   // R10
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(slot_valid) && $stable(fifth_hit)));
endmodule

bind spr_line_eval spr_line_eval_chk #(
   .NSPR(NSPR), .NSLOT(NSLOT), .ADDR_W(ADDR_W),
   .ATTR_BASE(ATTR_BASE), .PAT_BASE(PAT_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .slot_valid (slot_valid),
   .fifth_hit  (fifth_hit)
);

// File: tb/spr_line_eval_test.sv
`timescale 1ns/1ps
module spr_line_eval_test;
   localparam int NSPR = 32;
   localparam int NSLOT = 4;
   localparam int ADDR_W = 14;
   localparam int ATTR_BASE = 'h1B00;
   localparam int PAT_BASE = 'h3800;
   localparam int IDX_W = 5;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                   rst_n, start, size16, mag;
   logic [7:0]             line_num;
   logic                   mem_req;
   logic [ADDR_W-1:0]      mem_addr;
   logic [7:0]             mem_rdata;
   logic                   busy, done, fifth_hit;
   logic [NSLOT-1:0]       slot_valid;
   logic [NSLOT*IDX_W-1:0] slot_num;
   logic [NSLOT*8-1:0]     slot_y, slot_x, slot_pat, slot_color, slot_row0, slot_row1;
   logic [IDX_W-1:0]       fifth_idx;

   spr_line_eval uut (
      .clk(clk), .rst_n(rst_n), .start(start), .line_num(line_num),
      .size16(size16), .mag(mag), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .slot_valid(slot_valid),
      .slot_num(slot_num), .slot_y(slot_y), .slot_x(slot_x), .slot_pat(slot_pat),
      .slot_color(slot_color), .slot_row0(slot_row0), .slot_row1(slot_row1),
      .fifth_hit(fifth_hit), .fifth_idx(fifth_idx)
   );

   logic [7:0] sy [NSPR];
   logic [7:0] sx [NSPR];
   logic [7:0] sp [NSPR];
   logic [7:0] sc [NSPR];

   int nvec = 0;
   int nfail = 0;
   int nreads = 0;
   int unsigned seed = 32'h1234_5678;

   function automatic logic [7:0] pat_fn(int a);
      return 8'((a * 29) ^ (a >> 5) ^ 8'h3C);
   endfunction

   function automatic logic [7:0] rd_fn(int a);
      int off;
      if (a >= ATTR_BASE && a < ATTR_BASE + 4 * NSPR) begin
         off = a - ATTR_BASE;
         case (off % 4)
            0: return sy[off / 4];
            1: return sx[off / 4];
            2: return sp[off / 4];
            default: return sc[off / 4];
         endcase
      end
      return pat_fn(a);
   endfunction

   always @(posedge clk) begin
      if (mem_req) begin
         mem_rdata <= rd_fn(int'(mem_addr));
         nreads = nreads + 1;
      end
   end

   function automatic int rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 16) & 32'hFF);
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic fill_default();
      for (int i = 0; i < NSPR; i++) begin
         sy[i] = 8'd200;
         sx[i] = 8'(i * 7 + 3);
         sp[i] = 8'(i * 11 + 5);
         sc[i] = 8'(i * 13 + 1);
      end
   endtask

   // run one evaluation and compare all outputs with values derived from R3..R9
   task automatic run_eval(int ln, bit sz, bit mg, bit poke);
      int n, scanned, fi, h, row, k;
      bit f;
      int en [NSLOT];
      int er [NSLOT];
      int a0;
      @(negedge clk);
      nreads = 0;
      line_num = 8'(ln); size16 = sz; mag = mg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         start = 1'b1; line_num = 8'(ln ^ 8'h55); size16 = ~sz; mag = ~mg;
         @(negedge clk);
         start = 1'b0;
      end
      k = 0;
      while (!done && k < 400) begin
         @(negedge clk);
         k++;
      end
      chk("R10", "done seen", int'(done), 1);
      n = 0; scanned = 0; f = 0; fi = 0;
      for (int i = 0; i < NSPR; i++) begin
         scanned++;
         if (sy[i] == 8'hD0) break;
         row = (ln - int'(sy[i]) - 1) & 255;
         h = (sz ? 16 : 8) << mg;
         if (row < h) begin
            if (n < NSLOT) begin
               en[n] = i; er[n] = mg ? row >> 1 : row; n++;
            end else begin
               f = 1; fi = i; break;
            end
         end
      end
      // R9 read count
      chk("R9", "reads", nreads, scanned + n * (sz ? 6 : 5));
      chk("R5", "fifth_hit", int'(fifth_hit), int'(f));
      if (f) chk("R5", "fifth_idx", int'(fifth_idx), fi);
      for (int s = 0; s < NSLOT; s++) begin
         chk("R3", $sformatf("slot%0d valid", s), int'(slot_valid[s]), int'(s < n));
         if (s < n) begin
            chk("R4", $sformatf("slot%0d num", s), int'(slot_num[s*IDX_W +: IDX_W]), en[s]);
            chk("R7", $sformatf("slot%0d y", s), int'(slot_y[s*8 +: 8]), int'(sy[en[s]]));
            chk("R7", $sformatf("slot%0d x", s), int'(slot_x[s*8 +: 8]), int'(sx[en[s]]));
            chk("R7", $sformatf("slot%0d pat", s), int'(slot_pat[s*8 +: 8]), int'(sp[en[s]]));
            chk("R7", $sformatf("slot%0d color", s), int'(slot_color[s*8 +: 8]), int'(sc[en[s]]));
            a0 = sz ? PAT_BASE + (int'(sp[en[s]]) / 4) * 32 + er[s]
                    : PAT_BASE + int'(sp[en[s]]) * 8 + er[s];
            chk("R8", $sformatf("slot%0d row0", s), int'(slot_row0[s*8 +: 8]), int'(pat_fn(a0)));
            chk("R8", $sformatf("slot%0d row1", s), int'(slot_row1[s*8 +: 8]),
                sz ? int'(pat_fn(a0 + 16)) : 0);
         end
      end
      @(negedge clk);
      // R10 single-cycle pulse, then idle
      chk("R10", "done after pulse", int'(done), 0);
      chk("R10", "busy after pulse", int'(busy), 0);
   endtask

   initial begin
      #(8 * 190000);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      logic [NSLOT-1:0] hold_v;
      rst_n = 1'b0; start = 1'b0; line_num = '0; size16 = 1'b0; mag = 1'b0;
      fill_default();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "done", int'(done), 0);
      chk("R1", "mem_req", int'(mem_req), 0);
      chk("R1", "slot_valid", int'(slot_valid), 0);
      chk("R1", "fifth_hit", int'(fifth_hit), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: terminator in entry 0, one read only
      for (int i = 0; i < NSPR; i++) sy[i] = 8'hD0;
      run_eval(60, 0, 0, 0);
      fill_default();

      // two hits, 8-pixel, no doubling
      sy[3] = 8'd45; sy[10] = 8'd49; sy[20] = 8'hD0;
      run_eval(50, 0, 0, 0);
      run_eval(50, 1, 0, 0);
      fill_default();

      // R5: six covering sprites
      foreach (sy[i]) if (i inside {2, 5, 7, 9, 11, 13}) sy[i] = 8'd40;
      run_eval(41, 0, 0, 0);
      run_eval(41, 1, 1, 0);
      fill_default();

      // R6: covering sprite behind a mid-table terminator is not taken
      sy[1] = 8'd40; sy[4] = 8'hD0; sy[6] = 8'd40;
      run_eval(42, 0, 0, 0);
      chk("R6", "slot_valid", int'(slot_valid), 1);
      fill_default();

      // R3 modulo-256 row: Y=250, line 3 gives row 8
      sy[0] = 8'd250;
      for (int m = 0; m < 4; m++) run_eval(3, m[0], m[1], 0);
      fill_default();

      // R2: second start with changed inputs mid-run is ignored
      sy[0] = 8'd70; sy[8] = 8'd66;
      run_eval(72, 1, 0, 1);
      // R10: outputs hold while idle
      hold_v = slot_valid;
      repeat (10) @(negedge clk);
      chk("R10", "held slot_valid", int'(slot_valid), int'(hold_v));
      fill_default();

      // sweep over a pseudo-random table in all modes
      for (int i = 0; i < NSPR; i++) begin
         sy[i] = (i % 2 == 0) ? 8'(30 + rnd() % 64) : 8'(rnd());
         if (sy[i] == 8'hD0) sy[i] = 8'hD1;
         sp[i] = 8'(rnd());
         sx[i] = 8'(rnd());
         sc[i] = 8'(rnd());
      end
      for (int m = 0; m < 4; m++)
         for (int ln = 0; ln < 256; ln += 3)
            run_eval(ln, m[0], m[1], 0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule